// File: doc/BRIEF.md
# Partition bandwidth maximum regulator

This block grants access to a shared downstream memory port. It grants at most one request per cycle. Each grant is charged to the partition that asked for it. Every partition has a configured ceiling on its share of bandwidth and a flag that chooses how the ceiling is enforced. A hard partition that has gone over its ceiling gets nothing more until its measured use falls back under the ceiling. A soft partition that has gone over is still served, but only in cycles where no partition under its ceiling is waiting. Use is measured as the number of grants a partition has received within a fixed window of 2^WIN_LOG cycles.

Software sets the ceilings over a small memory-mapped register port. Each security state has its own partition selector and its own bank of per-partition settings. The secure flag of an access picks the bank. The selector picks which partition in that bank a configuration access reaches. The configuration word holds the ceiling as a 16-bit fraction below one, with the binary point just above bit 15, and the hard flag in bit 31. Only the upper FRAC_W bits of the fraction are stored.

Top module: `bw_max_regulator`

## Requirements
- R1: The configuration register sits at address 0x208 in both banks. Bit 31 is the hard flag and bits 15:0 are the ceiling fraction. Bits 30:16 always read as zero, and writing them changes nothing.
- R2: Only the upper FRAC_W bits of the fraction are stored (FRAC_W=8 by default). The lower 16-FRAC_W bits read as zero whatever was written.
- R3: The selector register sits at address 0x100, holds 16 bits, reads back what was written, and chooses the partition for configuration accesses. While the selector is NUM_PART or greater, configuration reads return zero and configuration writes change no partition.
- R4: reg_secure=1 reaches the secure bank and its own selector; reg_secure=0 reaches the non-secure bank. In req/gnt, bit p belongs to non-secure partition p and bit NUM_PART+p belongs to secure partition p.
- R5: After reset, both selectors are 0. Every partition has its hard flag clear and the stored fraction bits all ones (0x0000FF00 by default), so a partition requesting alone is granted every cycle.
- R6: Windows are 2^WIN_LOG cycles long and start at reset. A partition's grant count covers the grants clocked in the current window; all counts clear on the last edge of each window, and a grant on that edge is not counted. A partition is over its ceiling when count*2^16 > fraction*2^WIN_LOG; equality is not over.
- R7: A hard partition that is over its ceiling receives no grant.
- R8: A soft partition that is over its ceiling is granted only in cycles where no partition under its ceiling is requesting.
- R9: gnt has at most one bit set, and only on a requesting bit. Among candidates of the same class, the search starts just after the last granted index, which gives round-robin order.
- R10: reg_ready is always 1. A read returns reg_rdata with reg_rvalid high in the cycle after it is accepted. Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Access accepted (always 1) |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_secure | input | 1 | Bank select: 1 = secure |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| req | input | 2*NUM_PART | Per-partition transfer request |
| gnt | output | 2*NUM_PART | One-hot transfer grant |

## Verification
A single partition requests on every cycle of windows aligned to reset. It is set to a ceiling of 0x4000, first hard and then soft. The hard case gives five grants per window, which separates a strict compare from a non-strict one and shows blocking. The soft case gives a grant on every cycle, which shows that soft over-limit service continues when nobody else is waiting. With a soft over-limit partition requesting alongside an unthrottled one, the split comes out 5 to 11, which shows that the under-limit requester is preferred. Two unthrottled secure partitions requesting together must alternate. A small secure ceiling on bit NUM_PART gives three grants, which proves the bank mapping. The register table covers reset values, truncation, reserved bits, bank independence and out-of-range selectors, including a write with an out-of-range selector that must not alias into the other bank.

// File: rtl/bw_max_regulator.sv
module bw_max_regulator #(
  parameter int NUM_PART = 4,
  parameter int FRAC_W   = 8,
  parameter int WIN_LOG  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_valid,
  output logic                    reg_ready,
  input  logic [11:0]             reg_addr,
  input  logic [31:0]             reg_wdata,
  input  logic                    reg_we,
  input  logic                    reg_secure,
  output logic                    reg_rvalid,
  output logic [31:0]             reg_rdata,
  input  logic [2*NUM_PART-1:0]   req,
  output logic [2*NUM_PART-1:0]   gnt
);
  localparam int NREQ  = 2 * NUM_PART;
  localparam int IDX_W = $clog2(NREQ);
  localparam int CNT_W = WIN_LOG + 1;
  localparam logic [11:0] ADDR_SEL = 12'h100;
  localparam logic [11:0] ADDR_CFG = 12'h208;
  localparam logic [15:0] MAX_MASK = 16'hFFFF << (16 - FRAC_W);

  logic [15:0]      max_q [NREQ];
  logic [NREQ-1:0]  hard_q;
  logic [15:0]      sel_q [2];
  logic [WIN_LOG-1:0] win_q;
  logic [CNT_W-1:0] cnt_q [NREQ];
  logic [IDX_W-1:0] ptr_q, gidx;
  logic [NREQ-1:0]  over, hi, lo, cand;
  logic             found;

  logic [15:0]      cur_sel;
  logic             sel_ok;
  logic [IDX_W-1:0] widx;
  logic             win_end;

  assign reg_ready = 1'b1;
  assign cur_sel   = sel_q[reg_secure];
  assign sel_ok    = cur_sel < 16'(NUM_PART);
  assign widx      = reg_secure ? IDX_W'(NUM_PART) + IDX_W'(cur_sel) : IDX_W'(cur_sel);
  assign win_end   = (win_q == '1);

  for (genvar i = 0; i < NREQ; i++) begin : g_over
    assign over[i] = {cnt_q[i], 16'b0} > {1'b0, max_q[i], WIN_LOG'(0)};
  end

  assign hi   = req & ~over;
  assign lo   = req & over & ~hard_q;
  assign cand = (|hi) ? hi : lo;

  always_comb begin
    gnt   = '0;
    gidx  = '0;
    found = 1'b0;
    for (int k = 0; k < NREQ; k++) begin
      if (!found && cand[(int'(ptr_q) + k) % NREQ]) begin
        gnt[(int'(ptr_q) + k) % NREQ] = 1'b1;
        gidx  = IDX_W'((int'(ptr_q) + k) % NREQ);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREQ; i++) begin
        max_q[i] <= MAX_MASK;
        cnt_q[i] <= '0;
      end
      hard_q     <= '0;
      sel_q[0]   <= '0;
      sel_q[1]   <= '0;
      win_q      <= '0;
      ptr_q      <= '0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_valid && !reg_we;
      if (reg_valid && !reg_we) begin
        if (reg_addr == ADDR_SEL)
          reg_rdata <= {16'b0, cur_sel};
        else if (reg_addr == ADDR_CFG && sel_ok)
          reg_rdata <= {hard_q[widx], 15'b0, max_q[widx]};
        else
          reg_rdata <= '0;
      end
      if (reg_valid && reg_we) begin
        if (reg_addr == ADDR_SEL)
          sel_q[reg_secure] <= reg_wdata[15:0];
        else if (reg_addr == ADDR_CFG && sel_ok) begin
          max_q[widx]  <= reg_wdata[15:0] & MAX_MASK;
          hard_q[widx] <= reg_wdata[31];
        end
      end
      win_q <= win_q + 1'b1;
      for (int i = 0; i < NREQ; i++)
        cnt_q[i] <= win_end ? '0 : cnt_q[i] + CNT_W'(gnt[i]);
      if (found)
        ptr_q <= (gidx == IDX_W'(NREQ - 1)) ? '0 : gidx + 1'b1;
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));
  assert_hard_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & over & hard_q) == '0);
  assert_soft_yield_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & over)) |-> !(|(req & ~over)));
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid |-> (reg_rdata[30:16] == '0));
  assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_we) |=> reg_rvalid);
  for (genvar i = 0; i < NREQ; i++) begin : g_win_chk
    assert_window_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (cnt_q[i] == '0));
  end
endmodule

// File: tb/test_bw_max_regulator.sv
module test_bw_max_regulator;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NR = 2 * NP;
  localparam int WIN = 16;

  logic clk = 0, rst_n = 0;
  logic reg_valid = 0, reg_we = 0, reg_secure = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic reg_ready, reg_rvalid;
  logic [31:0] reg_rdata;
  logic [NR-1:0] req = 0, gnt;

  int checks = 0, failures = 0, edge_n = 0;
  int gcount [NR];
  int repeats;

  bw_max_regulator #(.NUM_PART(NP), .FRAC_W(8), .WIN_LOG(4)) i_bw_max_regulator (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_secure(reg_secure), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .req(req), .gnt(gnt));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) edge_n++;

  typedef struct packed {
    logic        sec;
    logic [11:0] addr;
    logic [31:0] wd;
    logic        we;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 12'h100, 32'h0,        1'b0, 32'h0},        // R5 R3 selector reset
    '{1'b0, 12'h208, 32'h0,        1'b0, 32'h0000FF00}, // R5 reset ceiling
    '{1'b1, 12'h100, 32'h2,        1'b1, 32'h0},
    '{1'b1, 12'h208, 32'hFFFFFFFF, 1'b1, 32'h0},
    '{1'b1, 12'h208, 32'h0,        1'b0, 32'h8000FF00}, // R1 R2
    '{1'b0, 12'h208, 32'h0,        1'b0, 32'h0000FF00}, // R4 other bank
    '{1'b1, 12'h100, 32'h0,        1'b0, 32'h2},        // R3 R4
    '{1'b0, 12'h100, 32'h6,        1'b1, 32'h0},
    '{1'b0, 12'h208, 32'h80001234, 1'b1, 32'h0},
    '{1'b0, 12'h208, 32'h0,        1'b0, 32'h0},        // R3 out of range
    '{1'b0, 12'h100, 32'h3,        1'b1, 32'h0},
    '{1'b0, 12'h208, 32'h0,        1'b0, 32'h0000FF00}, // R3
    '{1'b1, 12'h208, 32'h0,        1'b0, 32'h8000FF00}, // R3 no alias
    '{1'b1, 12'h100, 32'h0,        1'b1, 32'h0},
    '{1'b1, 12'h208, 32'h000012AB, 1'b1, 32'h0},
    '{1'b1, 12'h208, 32'h0,        1'b0, 32'h00001200}, // R2
    '{1'b0, 12'h300, 32'h0,        1'b0, 32'h0}         // R10
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_op(input logic sec, input logic [11:0] a, input logic [31:0] d,
                        input logic we, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    reg_valid = 1; reg_secure = sec; reg_addr = a; reg_wdata = d; reg_we = we;
    @(negedge clk);
    reg_valid = 0; reg_we = 0;
    rd = reg_rdata; rv = reg_rvalid;
  endtask

  task automatic align();
    forever begin
      @(posedge clk); #1;
      if (edge_n % WIN == 0) break;
    end
  endtask

  task automatic run(input logic [NR-1:0] v, input int n);
    int prev = -1;
    for (int i = 0; i < NR; i++) gcount[i] = 0;
    repeats = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      req = v;
      #1;
      for (int i = 0; i < NR; i++)
        if (gnt[i]) begin
          gcount[i]++;
          if (i == prev) repeats++;
          prev = i;
        end
      if ($countones(gnt) > 1 || (gnt & ~req) != 0) begin
        checks++; failures++;
        $display("FAIL R9 gnt=0x%0h req=0x%0h expected one-hot subset", gnt, req);
      end
    end
    req = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic rv;
    repeat (3) @(negedge clk);
    chk("R5 gnt idle in reset", int'(gnt), 0);
    rst_n = 1;
    chk("R10 ready", int'(reg_ready), 1);

    for (int k = 0; k < NV; k++) begin
      reg_op(TBL[k].sec, TBL[k].addr, TBL[k].wd, TBL[k].we, rd, rv);
      if (!TBL[k].we) begin
        chk($sformatf("R1/R2/R3/R4/R5 table row %0d rdata", k), int'(rd), int'(TBL[k].exp));
        chk($sformatf("R10 table row %0d rvalid", k), int'(rv), 1);
      end
    end

    align(); run(8'h04, WIN);
    chk("R5 unthrottled ns p2", gcount[2], WIN);

    reg_op(1'b0, 12'h100, 32'h0, 1'b1, rd, rv);
    reg_op(1'b0, 12'h208, 32'h80004000, 1'b1, rd, rv);
    align(); run(8'h01, 2 * WIN);
    chk("R7 R6 hard 0x4000 two windows", gcount[0], 10);

    reg_op(1'b0, 12'h208, 32'h00004000, 1'b1, rd, rv);
    align(); run(8'h01, WIN);
    chk("R8 soft alone served", gcount[0], WIN);
    align(); run(8'h03, WIN);
    chk("R8 soft p0 yields", gcount[0], 5);
    chk("R8 under-limit p1 preferred", gcount[1], 11);

    align(); run(8'hC0, 8);
    chk("R9 rr secure p2", gcount[6], 4);
    chk("R9 rr secure p3", gcount[7], 4);
    chk("R9 rr no repeats", repeats, 0);

    reg_op(1'b1, 12'h100, 32'h0, 1'b1, rd, rv);
    reg_op(1'b1, 12'h208, 32'h80002000, 1'b1, rd, rv);
    align(); run(8'h10, WIN);
    chk("R4 R7 secure p0 on bit 4", gcount[4], 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule